// File: doc/BRIEF.md
# Token-Ring Shared-Line Readout Sequencer

This block runs the readout of one front-end chip in a chain of chips that share a single open-drain data line. Access to the line goes around the chain as a token. The acquisition system starts the ring by raising the token input of the first chip. A chip that receives the token sends every record it has stored, one frame after another. It then raises its token output for one clock, and that output feeds the next chip in the chain.

A configuration bit can mark the chip as bypassed. A bypassed chip forwards the token at once and never drives the line. A chip with no stored records does the same. The block does not drive a logic level. It drives a pull-down enable: a pulled line reads 0 and a released line reads 1. When the chip does not hold the token, the line is always released.

Each frame is one start bit (line pulled) followed by the record, most significant bit first. Each bit lasts `CLKS_PER_BIT` clocks, which keeps the bit rate low on the heavily loaded bus. The record store sits outside the block. The block reads it through a valid/data/pop interface.

Top module: `token_readout_ctrl`

## Requirements
- R1: During and right after reset, `token_o`, `eod_o`, `rec_pop_o` and `data_pull_o` are all 0.
- R2: The token input passes through a two-stage synchroniser. If the chip is idle and `bypass_i` is 1 when a rising token edge is detected, `token_o` is 1 for exactly one clock, two clock edges after the first edge that samples the high token. In that case `data_pull_o` and `rec_pop_o` stay 0.
- R3: If the chip is idle and not bypassed, and `rec_avail_i` is 0 when the token edge is detected, the chip forwards the token with the same timing as R2. It does not pull the line, does not pop, and keeps `eod_o` at 0.
- R4: A frame lasts `(REC_W+1)*CLKS_PER_BIT` clocks. The first `CLKS_PER_BIT` clocks are the start bit, with `data_pull_o`=1. After that, each record bit, from bit `REC_W-1` down to bit 0, holds the line for `CLKS_PER_BIT` clocks. A 0 bit gives `data_pull_o`=1 and a 1 bit gives `data_pull_o`=0.
- R5: `rec_pop_o` is 1 for exactly one clock per record sent, in the clock just before that record's frame begins. It is only 1 while `rec_avail_i` is 1.
- R6: Records go out back to back. Between two frames the line is released for exactly one clock.
- R7: One clock after the last frame ends, `token_o` and `eod_o` are both 1 for exactly one clock. At the same time `data_pull_o` is 0, and the chip returns to idle.
- R8: A token input held high does not trigger the chip again. A rising token edge that arrives while the chip is sending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | Configuration: skip this chip in the ring |
| token_i | input | 1 | Token from the previous chip or from the acquisition system (asynchronous) |
| rec_avail_i | input | 1 | The record store holds at least one record |
| rec_data_i | input | REC_W | Oldest stored record |
| rec_pop_o | output | 1 | Removes the oldest record from the store |
| data_pull_o | output | 1 | Pull-down enable for the shared open-drain data line |
| token_o | output | 1 | One-clock token pulse to the next chip |
| eod_o | output | 1 | End-of-data pulse after this chip's last frame |

## Verification
The bench sweeps zero to three stored records, both bypass settings and two data patterns. For each run it predicts every clock of the line, the pop, the token output and the end-of-data pulse. A design that misses the frame length or the one-clock gap would shift every later bit and the token pulse, so those checks would fail. A design that drops the start bit or sends the bits LSB first would pull the line in the wrong clocks. A design that forwards a token without checking for stored records, or that pops while bypassed, would show an early token or a stray pop. The bench also drops the token and raises it again in the middle of a transfer, and leaves the token held high afterwards. An edge detector that retriggers would start a second transfer or emit a second token.

// File: rtl/token_readout_pkg.sv
package token_readout_pkg;
  typedef enum logic {
    RD_IDLE,
    RD_SEND
  } rd_state_e;
endpackage

// File: rtl/token_edge_sync.sv
module token_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic token_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], token_i};
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // R8
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int REC_W        = 8,
  parameter int CLKS_PER_BIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [REC_W-1:0] data_i,
  output logic             pull_o,
  output logic             done_o
);
  localparam int FRAME_W = REC_W + 1;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int CNT_W   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

  logic               active_q;
  logic [FRAME_W-1:0] frame_q;
  logic [BIT_W-1:0]   left_q;
  logic [CNT_W-1:0]   div_q;
  logic               bit_end;

  assign bit_end = (div_q == CNT_W'(CLKS_PER_BIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      frame_q  <= '0;
      left_q   <= '0;
      div_q    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_i) begin
        frame_q  <= {1'b0, data_i};   // start bit pulls the line
        left_q   <= BIT_W'(FRAME_W);
        div_q    <= '0;
        active_q <= 1'b1;
      end else if (active_q) begin
        if (bit_end) begin
          div_q   <= '0;
          frame_q <= {frame_q[FRAME_W-2:0], 1'b1};
          left_q  <= left_q - BIT_W'(1);
          if (left_q == BIT_W'(1)) begin
            active_q <= 1'b0;
            done_o   <= 1'b1;
          end
        end else begin
          div_q <= div_q + CNT_W'(1);
        end
      end
    end
  end

  assign pull_o = active_q & ~frame_q[FRAME_W-1];

  // R6
  no_overlap_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !active_q);
  // R4
  start_bit_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pull_o);
endmodule

// File: rtl/token_readout_ctrl.sv
module token_readout_ctrl
  import token_readout_pkg::*;
#(
  parameter int REC_W        = 8,
  parameter int CLKS_PER_BIT = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bypass_i,
  input  logic             token_i,
  input  logic             rec_avail_i,
  input  logic [REC_W-1:0] rec_data_i,
  output logic             rec_pop_o,
  output logic             data_pull_o,
  output logic             token_o,
  output logic             eod_o
);
  rd_state_e st_q, st_d;
  logic      tok_rise, frame_done, load, pass_now, finish_now;

  token_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .token_i(token_i),
    .rise_o (tok_rise)
  );

  frame_serializer #(.REC_W(REC_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_ser (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .data_i(rec_data_i),
    .pull_o(data_pull_o),
    .done_o(frame_done)
  );

  always_comb begin
    st_d       = st_q;
    load       = 1'b0;
    pass_now   = 1'b0;
    finish_now = 1'b0;
    unique case (st_q)
      RD_IDLE: if (tok_rise) begin
        if (!bypass_i && rec_avail_i) begin
          load = 1'b1;
          st_d = RD_SEND;
        end else begin
          pass_now = 1'b1;
        end
      end
      RD_SEND: if (frame_done) begin
        if (rec_avail_i) begin
          load = 1'b1;
        end else begin
          finish_now = 1'b1;
          st_d       = RD_IDLE;
        end
      end
      default: st_d = RD_IDLE;
    endcase
  end

  assign rec_pop_o = load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RD_IDLE;
      token_o <= 1'b0;
      eod_o   <= 1'b0;
    end else begin
      st_q    <= st_d;
      token_o <= pass_now | finish_now;
      eod_o   <= finish_now;
    end
  end

  // R7
  token_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |-> !data_pull_o);
  // R7
  token_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |=> !token_o);
  // R5
  pop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_pop_o |-> rec_avail_i);
  // R2
  bypass_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RD_IDLE && tok_rise && bypass_i) |=> (token_o && !data_pull_o && !eod_o));
endmodule

// File: tb/tb_token_readout_ctrl.sv
module tb_token_readout_ctrl;
  localparam int REC_W = 8;
  localparam int DIV   = 4;
  localparam int F     = (REC_W + 1) * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0;
  logic token = 1'b0;
  logic rec_avail;
  logic [REC_W-1:0] rec_data;
  logic pop, pull, tok_out, eod;

  logic [REC_W-1:0] mem [4];
  int n_cur = 0;
  int idx = 0;
  logic src_clr = 1'b0;
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign rec_avail = (idx < n_cur);
  assign rec_data  = (idx < 4) ? mem[idx] : '0;

  always @(posedge clk) begin
    if (src_clr) idx <= 0;
    else if (pop) idx <= idx + 1;
  end

  token_readout_ctrl #(.REC_W(REC_W), .CLKS_PER_BIT(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bypass_i(bypass), .token_i(token),
    .rec_avail_i(rec_avail), .rec_data_i(rec_data), .rec_pop_o(pop),
    .data_pull_o(pull), .token_o(tok_out), .eod_o(eod)
  );

  task automatic chk(string tag, logic act, logic exp, int j);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s j=%0d actual=%0b expected=%0b", tag, j, act, exp);
    end
  endtask

  task automatic run(int n, bit byp, int pat);
    bit sending;
    int last, tok_j;
    sending = !byp && (n > 0);
    for (int i = 0; i < 4; i++) mem[i] = REC_W'((pat * 8'h5B) ^ (i * 37 + 8'h96));
    @(negedge clk);
    n_cur = n; bypass = byp; src_clr = 1'b1;
    @(negedge clk);
    src_clr = 1'b0; token = 1'b1;
    tok_j = sending ? 2 + n * (F + 1) : 2;
    last  = tok_j + 20;
    for (int j = 0; j <= last; j++) begin
      logic e_pull, e_pop;
      @(negedge clk);
      e_pull = 1'b0; e_pop = 1'b0;
      if (sending) begin
        for (int r = 0; r < n; r++) begin
          int lr;
          lr = 2 + r * (F + 1);
          if (j == lr - 1) e_pop = 1'b1;
          if (j >= lr && j < lr + F) begin
            int b;
            b = (j - lr) / DIV;
            e_pull = (b == 0) ? 1'b1 : ~mem[r][REC_W - b];
          end
        end
      end
      // R4 frame bits, R6 gap, R2/R3 no pull when passing
      chk(sending ? "R4/R6 pull" : (byp ? "R2 pull" : "R3 pull"), pull, e_pull, j);
      chk(sending ? "R5 pop" : "R2/R3 pop", pop, e_pop, j);
      // R7 end token, R8 no retrigger
      chk(sending ? "R7 token" : "R2/R3 token (R8)", tok_out, j == tok_j, j);
      chk(sending ? "R7 eod" : "R3 eod", eod, sending && j == tok_j, j);
      // R8: edge during transfer must be ignored
      if (sending && j == 4) token = 1'b0;
      if (sending && j == 7) token = 1'b1;
    end
    token = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 token", tok_out, 1'b0, 0);
    chk("R1 pull", pull, 1'b0, 0);
    chk("R1 pop", pop, 1'b0, 0);
    chk("R1 eod", eod, 1'b0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 token post", tok_out, 1'b0, 0);
    chk("R1 pull post", pull, 1'b0, 0);
    for (int pat = 0; pat < 2; pat++)
      for (int byp = 0; byp < 2; byp++)
        for (int n = 0; n < 4; n++)
          run(n, byp[0], pat);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
    end
  end
endmodule